// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital front end of a six-bit step attenuator with half-decibel resolution. It accepts a parallel or a serial control word and passes it through a single level-sensitive output latch. It then drives a registered attenuation word to the switch array. The mode select, the latch enable, the serial pair, the parallel word and the two preset pins are all brought into the system clock domain through two-flop synchronisers. The serial clock is edge-detected there.

A synchronous reset models power-up. While reset is held, the output word is zero. After release, a boot state waits for the synchronisers to settle and then picks the starting word. In serial mode it samples the parallel pins. In parallel mode with the latch enable low, it reads a four-entry preset table. In parallel mode with the latch enable high, it tracks the parallel pins.

A rate gate sits behind the latch. When the slow-update input is set, it spaces output changes by at least `HOLD_CYCLES` clocks, which is 40 µs at the default 200 MHz. A change that arrives during the hold-off is kept as pending, and only the latest such value is kept. The pending value is applied when the hold-off ends.

Two state machines carry the control:
- Latch machine: states `L_BOOT`, `L_OPEN` and `L_SHUT`.
  - `L_BOOT` leaves after the settle count. It moves to `L_OPEN` if the synchronised latch enable is high, and to `L_SHUT` otherwise.
  - `L_OPEN` goes to `L_SHUT` when the latch enable falls.
  - `L_SHUT` goes to `L_OPEN` when the latch enable rises.
- Rate gate: states `G_FREE` and `G_HOLD`.
  - `G_FREE` goes to `G_HOLD` when, in slow mode, the latched word differs from the output.
  - `G_HOLD` goes to `G_FREE` when its counter reaches zero.
  - Clearing the slow-update input returns the gate to `G_FREE` at once.

Top module: `step_atten_ctrl`

## Requirements
- R1: The attenuation word bit weights are: bit 5 = 16 dB, bit 4 = 8 dB, bit 3 = 4 dB, bit 2 = 2 dB, bit 1 = 1 dB, bit 0 = 0.5 dB. All zeros is the minimum-loss reference state and all ones is 31.5 dB. The word is zero while reset is held.
- R2: When `ser_mode` = 0 the parallel inputs are the data source. When `ser_mode` = 1 the serial shift register is the source.
- R3: In parallel mode, the output follows `par_word` while `latch_en` is high. It holds its value while `latch_en` is low.
- R4: In serial mode, a rising edge of `ser_clk` shifts `ser_dat` into bit 0 and moves the other bits up, whatever the state of `latch_en`. The most significant bit is sent first, so after six clocks the register holds the sent word.
- R5: In serial mode, the output follows the shift register while `latch_en` is high and stays frozen while it is low. Loading with `latch_en` low and then pulsing it high updates the output once.
- R6: After reset in serial mode, the output starts at the value present on `par_word`.
- R7: After reset in parallel mode with `latch_en` low, the output starts at a preset chosen by `preset_sel`: 2'b00 gives 6'b000000, 2'b10 gives 6'b010000 (8 dB), 2'b01 gives 6'b100000 (16 dB), and 2'b11 gives 6'b111110 (31 dB).
- R8: After reset in parallel mode with `latch_en` high, `preset_sel` has no effect and the output starts at, and follows, `par_word`.
- R9: With `slow_mode` = 1, successive output changes are at least `HOLD_CYCLES` clocks apart. A request made during the hold-off is applied when it ends, and only the latest request is applied.
- R10: With `slow_mode` = 0, every latched change reaches the output without hold-off.
- R11: A change on the input pins reaches `atten_word` within four clock cycles: two synchroniser stages, the latch register and the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; models power-up |
| ser_mode | input | 1 | 0 = parallel source, 1 = serial source |
| par_word | input | 6 | Parallel control word; also the serial-mode starting value |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, most significant bit first |
| latch_en | input | 1 | Output latch enable, transparent when high |
| preset_sel | input | 2 | Power-up preset selector for parallel mode |
| slow_mode | input | 1 | 1 = limit output change rate |
| atten_word | output | 6 | Registered attenuation word |

## Verification
Each preset encoding is tried across separate resets, along with a reset with the latch open. This distinguishes the preset table from pin sampling, and parallel start-up from serial start-up. A serial word is shifted with the latch shut and then pulsed through. A second word is shifted with the latch open. Together these separate the role of the latch from the shift order, and an asymmetric pattern exposes a reversed bit order. In slow mode, a burst of three quick parallel changes checks both the hold-off and that only the latest request survives. A run of back-to-back changes in fast mode confirms that no hold-off is applied.

// File: rtl/step_atten_pkg.sv
package step_atten_pkg;
    typedef enum logic [1:0] {
        L_BOOT = 2'd0,
        L_OPEN = 2'd1,
        L_SHUT = 2'd2
    } latch_st_t;

    typedef enum logic {
        G_FREE = 1'b0,
        G_HOLD = 1'b1
    } gate_st_t;
endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/shift_sipo.sv
module shift_sipo #(
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic [WORD_W-1:0] sr_q
);
    logic sclk_d;
    logic rise;

    assign rise = en && sclk_s && !sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= sclk_s;
            sr_q   <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (rise) begin
                sr_q <= {sr_q[WORD_W-2:0], sdat_s};
            end
        end
    end

    // R4: each detected edge moves the word up by one and appends the data bit
    assert_msb_first_R4: assert property (@(posedge clk) disable iff (rst)
        rise |=> (sr_q == {$past(sr_q[WORD_W-2:0]), $past(sdat_s)}));

    // R4: without a detected edge the register keeps its contents
    assert_no_edge_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(sr_q));
endmodule

// File: rtl/latch_fsm.sv
module latch_fsm
    import step_atten_pkg::*;
#(
    parameter int WORD_W     = 6,
    parameter int BOOT_WAIT  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_s,
    input  logic              le_s,
    input  logic [WORD_W-1:0] par_s,
    input  logic [WORD_W-1:0] sr,
    input  logic [1:0]        preset_s,
    output logic [WORD_W-1:0] word_q,
    output logic              ready
);
    localparam int BCW = (BOOT_WAIT > 1) ? $clog2(BOOT_WAIT) : 1;
    localparam logic [BCW-1:0] BOOT_LAST = BCW'(BOOT_WAIT - 1);

    latch_st_t         st_q, st_d;
    logic [BCW-1:0]    bcnt_q, bcnt_d;
    logic [WORD_W-1:0] word_d;
    logic [WORD_W-1:0] src;

    function automatic logic [WORD_W-1:0] preset_word(input logic [1:0] sel);
        logic [WORD_W-1:0] w;
        w = '0;
        unique case (sel)
            2'b00: w = '0;
            2'b10: w[WORD_W-2] = 1'b1;
            2'b01: w[WORD_W-1] = 1'b1;
            2'b11: begin
                w    = '1;
                w[0] = 1'b0;
            end
            default: w = '0;
        endcase
        return w;
    endfunction

    assign src   = mode_s ? sr : par_s;
    assign ready = (st_q != L_BOOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= L_BOOT;
            bcnt_q <= '0;
        end else begin
            st_q   <= st_d;
            bcnt_q <= bcnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        bcnt_d = bcnt_q;
        word_d = word_q;
        unique case (st_q)
            L_BOOT: begin
                if (bcnt_q == BOOT_LAST) begin
                    if (mode_s || le_s) begin
                        word_d = par_s;
                    end else begin
                        word_d = preset_word(preset_s);
                    end
                    st_d = le_s ? L_OPEN : L_SHUT;
                end else begin
                    bcnt_d = bcnt_q + 1'b1;
                end
            end
            L_OPEN: begin
                if (le_s) begin
                    word_d = src;
                end else begin
                    st_d = L_SHUT;
                end
            end
            L_SHUT: begin
                if (le_s) begin
                    word_d = src;
                    st_d   = L_OPEN;
                end
            end
            default: st_d = L_BOOT;
        endcase
    end

    // R3 / R5: a shut latch keeps its word
    assert_shut_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q != L_BOOT && !le_s) |=> $stable(word_q));

    // R5 / R3: an open latch passes the selected source one cycle later
    assert_open_tracks_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q != L_BOOT && le_s) |=> (word_q == $past(src)));

    // R7: leaving boot in parallel mode with the latch shut loads a preset
    assert_boot_preset_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == L_BOOT && bcnt_q == BOOT_LAST && !mode_s && !le_s)
        |=> (word_q == preset_word($past(preset_s))));
endmodule

// File: rtl/rate_gate.sv
module rate_gate
    import step_atten_pkg::*;
#(
    parameter int WORD_W      = 6,
    parameter int HOLD_CYCLES = 8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ready,
    input  logic              slow,
    input  logic [WORD_W-1:0] req,
    output logic [WORD_W-1:0] out_q
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES - 1);

    gate_st_t          st_q, st_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [WORD_W-1:0] out_d;
    logic              rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= G_FREE;
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            rdy_q <= ready;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        out_d = out_q;
        if (!rdy_q || !slow) begin
            st_d  = G_FREE;
            cnt_d = '0;
            out_d = req;
        end else begin
            unique case (st_q)
                G_FREE: begin
                    if (req != out_q) begin
                        out_d = req;
                        cnt_d = RELOAD;
                        st_d  = G_HOLD;
                    end
                end
                G_HOLD: begin
                    if (cnt_q == '0) begin
                        st_d = G_FREE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: st_d = G_FREE;
            endcase
        end
    end

    // R9: no output change while holding off in slow mode
    assert_hold_window_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == G_HOLD && slow && rdy_q) |=> $stable(out_q));

    // R10: in fast mode the output copies the request on the next edge
    assert_free_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (!slow && rdy_q) |=> (out_q == $past(req)));

    // R9: a change out of the free state always opens a hold-off window
    assert_window_opens_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == G_FREE && slow && rdy_q && req != out_q) |=> (st_q == G_HOLD));
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
    parameter int WORD_W      = 6,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_mode,
    input  logic [WORD_W-1:0] par_word,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              latch_en,
    input  logic [1:0]        preset_sel,
    input  logic              slow_mode,
    output logic [WORD_W-1:0] atten_word
);
    localparam int SW = WORD_W + 6;

    logic [SW-1:0]     pins_s;
    logic              mode_s, le_s, sclk_s, sdat_s;
    logic [1:0]        preset_s;
    logic [WORD_W-1:0] par_s;
    logic [WORD_W-1:0] sr;
    logic [WORD_W-1:0] word_q;
    logic              ready;

    sync_bits #(
        .WIDTH  (SW),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .d   ({ser_mode, latch_en, ser_clk, ser_dat, preset_sel, par_word}),
        .q   (pins_s)
    );

    assign {mode_s, le_s, sclk_s, sdat_s, preset_s, par_s} = pins_s;

    shift_sipo #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .en     (mode_s),
        .sclk_s (sclk_s),
        .sdat_s (sdat_s),
        .sr_q   (sr)
    );

    latch_fsm #(
        .WORD_W    (WORD_W),
        .BOOT_WAIT (SYNC_STAGES)
    ) u_latch (
        .clk      (clk),
        .rst      (rst),
        .mode_s   (mode_s),
        .le_s     (le_s),
        .par_s    (par_s),
        .sr       (sr),
        .preset_s (preset_s),
        .word_q   (word_q),
        .ready    (ready)
    );

    rate_gate #(
        .WORD_W      (WORD_W),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_gate (
        .clk   (clk),
        .rst   (rst),
        .ready (ready),
        .slow  (slow_mode),
        .req   (word_q),
        .out_q (atten_word)
    );

    // R1: the output word is zero while reset is held
    assert_reset_zero_R1: assert property (@(posedge clk)
        $past(rst) |-> (atten_word == '0));
endmodule

// File: tb/step_atten_ctrl_bench.sv
module step_atten_ctrl_bench;
    localparam int W    = 6;
    localparam int HOLD = 50;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_mode = 1'b0;
    logic [W-1:0] par_word = '0;
    logic         ser_clk = 1'b0;
    logic         ser_dat = 1'b0;
    logic         latch_en = 1'b0;
    logic [1:0]   preset_sel = 2'b00;
    logic         slow_mode = 1'b0;
    logic [W-1:0] atten_word;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [W-1:0] q_exp [$];
    string        q_tag [$];

    always #2.5 clk = ~clk;

    step_atten_ctrl #(
        .WORD_W      (W),
        .SYNC_STAGES (2),
        .HOLD_CYCLES (HOLD)
    ) u_step_atten_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ser_mode   (ser_mode),
        .par_word   (par_word),
        .ser_clk    (ser_clk),
        .ser_dat    (ser_dat),
        .latch_en   (latch_en),
        .preset_sel (preset_sel),
        .slow_mode  (slow_mode),
        .atten_word (atten_word)
    );

    // monitor: pop one expectation per falling edge and compare
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            automatic logic [W-1:0] e = q_exp.pop_front();
            automatic string        t = q_tag.pop_front();
            checks++;
            if (atten_word !== e) begin
                failures++;
                $display("FAIL %s actual=%b expected=%b", t, atten_word, e);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_word(input logic [W-1:0] e, input string tag);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        cyc(2);
    endtask

    task automatic boot(input logic m, input logic le, input logic [1:0] ps,
                        input logic [W-1:0] pw);
        @(negedge clk);
        rst        = 1'b1;
        ser_mode   = m;
        latch_en   = le;
        preset_sel = ps;
        par_word   = pw;
        cyc(5);
        rst = 1'b0;
        cyc(8);
    endtask

    task automatic send_serial(input logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) begin
            ser_dat = w[i];
            cyc(4);
            ser_clk = 1'b1;
            cyc(4);
            ser_clk = 1'b0;
            cyc(4);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1: zero during reset
        cyc(3);
        expect_word(6'b000000, "R1 reset state");

        // R7: preset table, parallel mode with latch shut
        boot(1'b0, 1'b0, 2'b10, 6'h2A);
        expect_word(6'b010000, "R7 preset 10 -> 8 dB");
        par_word = 6'h3F;
        cyc(8);
        expect_word(6'b010000, "R3 shut latch ignores parallel pins");
        boot(1'b0, 1'b0, 2'b01, 6'h2A);
        expect_word(6'b100000, "R7 preset 01 -> 16 dB");
        boot(1'b0, 1'b0, 2'b11, 6'h2A);
        expect_word(6'b111110, "R7 preset 11 -> 31 dB");
        boot(1'b0, 1'b0, 2'b00, 6'h2A);
        expect_word(6'b000000, "R7 preset 00 -> reference");

        // R8: latch open at power-up ignores presets
        boot(1'b0, 1'b1, 2'b11, 6'h15);
        expect_word(6'h15, "R8 open latch at boot uses pins");
        par_word = 6'h3F;
        cyc(8);
        expect_word(6'h3F, "R1 all ones 31.5 dB passes");
        par_word = 6'h00;
        cyc(8);
        expect_word(6'h00, "R3 open latch follows pins");

        // R11: latency of exactly four edges
        par_word = 6'h09;
        cyc(3);
        expect_word(6'h00, "R11 not yet at three cycles");
        cyc(1);
        expect_word(6'h09, "R11 visible within four cycles");

        // R3: shut then reopen
        latch_en = 1'b0;
        cyc(6);
        par_word = 6'h0C;
        cyc(8);
        expect_word(6'h09, "R3 shut latch holds");
        latch_en = 1'b1;
        cyc(8);
        expect_word(6'h0C, "R3 reopened latch updates");

        // R6: serial mode start value from parallel pins
        boot(1'b1, 1'b0, 2'b11, 6'h27);
        expect_word(6'h27, "R6 serial boot from pins");
        par_word = 6'h01;
        cyc(8);
        expect_word(6'h27, "R2 serial mode ignores parallel pins");

        // R4/R5: load shut, then pulse
        send_serial(6'b101101);
        expect_word(6'h27, "R5 shut latch during shifting");
        latch_en = 1'b1;
        cyc(6);
        latch_en = 1'b0;
        cyc(8);
        expect_word(6'b101101, "R4 msb-first word after pulse");
        par_word = 6'h3F;
        cyc(8);
        expect_word(6'b101101, "R5 frozen after pulse");

        // R4: shifting with latch open
        latch_en = 1'b1;
        send_serial(6'b010011);
        cyc(8);
        expect_word(6'b010011, "R4 shift with latch open");
        latch_en = 1'b0;
        cyc(6);

        // R9: slow mode hold-off with latest request kept
        slow_mode = 1'b1;
        boot(1'b0, 1'b1, 2'b00, 6'h05);
        expect_word(6'h05, "R9 slow boot value");
        par_word = 6'h01;
        cyc(3);
        par_word = 6'h02;
        cyc(3);
        par_word = 6'h03;
        cyc(12);
        expect_word(6'h01, "R9 first change applied, later held");
        cyc(16);
        expect_word(6'h01, "R9 still inside window");
        cyc(40);
        expect_word(6'h03, "R9 latest pending applied");

        // R10: fast mode follows every change
        slow_mode = 1'b0;
        cyc(4);
        for (int k = 0; k < 4; k++) begin
            par_word = 6'(k * 13 + 7);
            cyc(5);
            expect_word(6'(k * 13 + 7), "R10 fast change applied");
        end

        cyc(4);
        finish_run();
    end
endmodule